// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This combinational block produces the second operand for a 32-bit data-processing datapath, together with a carry bit taken from the shifter. In shift mode it takes a register value and shifts or rotates it. The shift type comes from a 3-bit field. The amount comes either from a 5-bit immediate or from the low byte of a register. In immediate-operand mode it instead forms the operand from an 8-bit constant rotated right by twice a 4-bit field.

Next to the carry result, the block drives a qualifier, `carry_valid`. When no bits leave the word, `carry_valid` is low and the incoming carry flag passes straight through. The downstream flag logic can then update or keep the carry flag without decoding the instruction again. Instruction decoding, the register file and the ALU sit outside this block.

Top module: `op_shifter`

## Requirements
- R1: Shift type encodes as follows: 000 LSL by immediate, 001 LSL by register, 010 LSR by immediate, 011 LSR by register, 100 ASR by immediate, 101 ASR by register, 110 ROR by immediate, 111 ROR by register. Bit 0 selects the register amount.
- R2: LSL by an immediate amount of 0 returns the value unchanged, with `carry_valid` low.
- R3: For LSR and ASR, an immediate amount of 0 shifts by 32. LSR gives 0 with carry equal to bit 31. ASR gives 32 copies of bit 31, with carry equal to bit 31.
- R4: ROR with an immediate amount of 0 rotates right by one bit through the carry. The result is {carry_in, value[31:1]} and the carry-out is value[0].
- R5: A register amount uses only bits 7:0 of `rs_val`. When that byte is 0 (for example 256), the value passes through unchanged with `carry_valid` low.
- R6: For amounts 1 to 31, LSL, LSR, ASR and ROR give the usual result. The carry-out is the last bit shifted out: value[32-n] for LSL and value[n-1] for the others.
- R7: LSL or LSR by a register amount of exactly 32 returns 0. The carry is value[0] for LSL and value[31] for LSR.
- R8: LSL or LSR by a register amount above 32 returns 0 with carry 0. ASR by a register amount of 32 or more fills every bit with the sign bit, and the carry equals the sign bit.
- R9: ROR by a nonzero register amount that is a multiple of 32 returns the value unchanged with carry equal to bit 31. Any other amount rotates by the amount modulo 32.
- R10: In immediate-operand mode, the operand is the zero-extended 8-bit constant rotated right by 2 × `rot_field`.
- R11: In immediate-operand mode with `rot_field` = 0, `carry_valid` is low. With a nonzero `rot_field`, `carry_valid` is high and the carry-out equals operand bit 31.
- R12: Whenever `carry_valid` is low, `carry_out` equals `carry_in`. Whenever it is high, `carry_out` is the shifter carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_mode | input | 1 | 1 selects the rotated 8-bit constant; 0 selects the register shift path |
| value | input | 32 | Register value to shift |
| kind | input | 3 | Shift type and amount source |
| imm_amt | input | 5 | Immediate shift amount |
| rs_val | input | 32 | Register holding the shift amount (low byte used) |
| imm_const | input | 8 | Constant for immediate-operand mode |
| rot_field | input | 4 | Rotate field; the rotation is twice this value |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Shifter carry, or carry_in when no shift happens |
| carry_valid | output | 1 | High when carry_out comes from the shifter |

## Verification
The bench sweeps every immediate amount and a dense set of register amounts around 0, 31, 32, 33, 255 and 256, for all eight shift types, both carry inputs and several bit patterns. It also sweeps every constant and rotate field of immediate-operand mode.

Each sweep targets a specific class of fault:
- A design that treats a zero immediate as a true zero for LSR, ASR or ROR would return the input unchanged instead of 0, a sign fill or the through-carry rotate.
- A design that uses more than the low byte of the amount register would shift on 256.
- A design that reduces the amount modulo 32 for LSL or LSR would return nonzero data at 32 and above.
- A design that takes the ROR-by-32 carry from bit 0 would report the wrong flag.
- A design that drives a shifter carry when nothing shifts would clobber the carry flag.

// File: rtl/op_shifter.sv
module op_shifter #(
  parameter int DW    = 32,
  parameter int AMT_W = 8,
  parameter int K_W   = 8,
  parameter int ROT_W = 4
) (
  input  logic                   imm_mode,
  input  logic [DW-1:0]          value,
  input  logic [2:0]             kind,
  input  logic [$clog2(DW)-1:0]  imm_amt,
  input  logic [DW-1:0]          rs_val,
  input  logic [K_W-1:0]         imm_const,
  input  logic [ROT_W-1:0]       rot_field,
  input  logic                   carry_in,
  output logic [DW-1:0]          operand,
  output logic                   carry_out,
  output logic                   carry_valid
);
  localparam int SW = $clog2(DW);
  localparam logic [1:0] T_LSL = 2'b00;
  localparam logic [1:0] T_LSR = 2'b01;
  localparam logic [1:0] T_ASR = 2'b10;

  function automatic logic [DW-1:0] rotr(input logic [DW-1:0] x, input logic [SW-1:0] r);
    logic [2*DW-1:0] d;
    d = {x, x} >> r;
    return d[DW-1:0];
  endfunction

  logic [AMT_W-1:0] reg_amt;
  logic [AMT_W:0]   amt;
  logic             rrx;
  assign reg_amt = rs_val[AMT_W-1:0];

  always_comb begin
    rrx = 1'b0;
    if (kind[0])
      amt = {1'b0, reg_amt};
    else if (imm_amt == '0 && kind[2:1] != T_LSL) begin
      if (kind[2:1] == T_LSR || kind[2:1] == T_ASR)
        amt = (AMT_W+1)'(DW);
      else begin
        amt = '0;
        rrx = 1'b1;
      end
    end else
      amt = (AMT_W+1)'(imm_amt);
  end

  logic [DW:0]        lsl_w, lsr_w;
  logic signed [DW:0] asr_src, asr_w;
  logic [DW-1:0]      ror_w;
  assign lsl_w   = {1'b0, value} << amt;
  assign lsr_w   = {value, 1'b0} >> amt;
  assign asr_src = {value, 1'b0};
  assign asr_w   = asr_src >>> amt;
  assign ror_w   = rotr(value, amt[SW-1:0]);

  logic [DW-1:0] sh_res;
  logic          sh_c;
  always_comb begin
    case (kind[2:1])
      T_LSL:   begin sh_res = lsl_w[DW-1:0]; sh_c = lsl_w[DW]; end
      T_LSR:   begin sh_res = lsr_w[DW:1];   sh_c = lsr_w[0];  end
      T_ASR:   begin sh_res = asr_w[DW:1];   sh_c = asr_w[0];  end
      default: begin
        if (rrx) begin sh_res = {carry_in, value[DW-1:1]}; sh_c = value[0]; end
        else     begin sh_res = ror_w; sh_c = ror_w[DW-1]; end
      end
    endcase
  end

  logic [DW-1:0] imm_res;
  logic [SW-1:0] imm_rot;
  assign imm_rot = SW'({rot_field, 1'b0});
  assign imm_res = rotr(DW'(imm_const), imm_rot);

  logic sel_valid, sel_c;
  assign operand     = imm_mode ? imm_res : sh_res;
  assign sel_valid   = imm_mode ? (rot_field != '0) : (rrx || amt != '0);
  assign sel_c       = imm_mode ? imm_res[DW-1] : sh_c;
  assign carry_valid = sel_valid;
  assign carry_out   = sel_valid ? sel_c : carry_in;

  always_comb begin
    if (!carry_valid)
      a_r12_carry_hold: assert (carry_out == carry_in);
    if (imm_mode && rot_field == '0)
      a_r11_zero_rot: assert (operand == DW'(imm_const) && !carry_valid);
    if (!imm_mode && kind[0] && rs_val[AMT_W-1:0] == '0)
      a_r5_low_byte_zero: assert (operand == value && !carry_valid);
    if (!imm_mode && kind == 3'b101 && rs_val[AMT_W-1:0] >= AMT_W'(DW))
      a_r8_asr_fill: assert (($countones(operand) == 0 || $countones(operand) == DW)
                              && operand[0] == value[DW-1] && carry_out == value[DW-1]);
    if (!imm_mode && kind == 3'b110 && imm_amt == '0)
      a_r4_rrx: assert (operand == {carry_in, value[DW-1:1]} && carry_out == value[0]);
    if (!imm_mode && kind == 3'b000 && imm_amt == '0)
      a_r2_lsl_zero: assert (operand == value && !carry_valid);
  end
endmodule

// File: tb/sim_op_shifter.sv
module sim_op_shifter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        imm_mode;
  logic [31:0] value;
  logic [2:0]  kind;
  logic [4:0]  imm_amt;
  logic [31:0] rs_val;
  logic [7:0]  imm_const;
  logic [3:0]  rot_field;
  logic        carry_in;
  logic [31:0] operand;
  logic        carry_out, carry_valid;

  op_shifter u0 (.imm_mode(imm_mode), .value(value), .kind(kind), .imm_amt(imm_amt),
                 .rs_val(rs_val), .imm_const(imm_const), .rot_field(rot_field),
                 .carry_in(carry_in), .operand(operand), .carry_out(carry_out),
                 .carry_valid(carry_valid));

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  always @(posedge clk) cycles <= cycles + 1;

  function automatic string tag_of(input logic im, input logic [2:0] k, input int n, input logic [3:0] rf);
    if (im) return (rf == 0) ? "R11" : "R10";
    if (!k[0] && n == 0) begin
      if (k[2:1] == 2'b00) return "R2";
      if (k[2:1] == 2'b11) return "R4";
      return "R3";
    end
    if (k[0] && n == 0) return "R5";
    if (k[0] && k[2:1] == 2'b11 && n >= 32) return "R9";
    if (k[0] && n == 32) return (k[2:1] == 2'b10) ? "R8" : "R7";
    if (k[0] && n > 32) return "R8";
    return "R6";
  endfunction

  task automatic apply_check();
    logic [31:0] r;
    logic c, v;
    int n;
    r = value; c = carry_in; v = 1'b0; n = 0;
    if (imm_mode) begin
      r = {24'd0, imm_const};
      for (int i = 0; i < 2 * int'(rot_field); i++) r = {r[0], r[31:1]};
      if (rot_field != 0) begin c = r[31]; v = 1'b1; end
    end else begin
      n = kind[0] ? int'(rs_val[7:0]) : int'(imm_amt);
      if (!kind[0] && imm_amt == 0 && kind[2:1] == 2'b11) begin
        c = r[0]; r = {carry_in, r[31:1]}; v = 1'b1;
      end else begin
        int m;
        m = n;
        if (!kind[0] && imm_amt == 0 && (kind[2:1] == 2'b01 || kind[2:1] == 2'b10)) m = 32;
        for (int i = 0; i < m; i++) begin
          case (kind[2:1])
            2'b00: begin c = r[31]; r = r << 1; end
            2'b01: begin c = r[0]; r = r >> 1; end
            2'b10: begin c = r[0]; r = {r[31], r[31:1]}; end
            default: begin c = r[0]; r = {r[0], r[31:1]}; end
          endcase
        end
        if (m != 0) v = 1'b1;
      end
    end
    #2;
    n_checks++;
    if (operand !== r || carry_out !== c || carry_valid !== v) begin
      n_fail++;
      $display("FAIL %s im=%0b kind=%0d n=%0d val=%h: got %h c=%0b v=%0b expected %h c=%0b v=%0b",
               tag_of(imm_mode, kind, n, rot_field), imm_mode, kind, n, value,
               operand, carry_out, carry_valid, r, c, v);
    end
    #2;
  endtask

  logic [31:0] pats [6];
  int reg_amts [20];

  initial begin
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hDEAD_BEEF;
    pats[3] = 32'h0000_0000; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1234_5678;
    reg_amts = '{0, 1, 2, 7, 16, 30, 31, 32, 33, 34, 63, 64, 65, 96, 128, 200, 255, 256, 257, 288};
    imm_mode = 0; value = 0; kind = 0; imm_amt = 0; rs_val = 0;
    imm_const = 0; rot_field = 0; carry_in = 0;
    #3;
    n_checks++;
    if (operand !== 32'd0 || carry_valid !== 1'b0 || carry_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 idle state: got %h v=%0b expected 0 v=0", operand, carry_valid);
    end
    // R1 R2 R3 R4 R6 immediate amounts
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 8; k += 2)
        for (int a = 0; a < 32; a++)
          for (int ci = 0; ci < 2; ci++) begin
            imm_mode = 0; value = pats[p]; kind = 3'(k); imm_amt = 5'(a); carry_in = ci[0];
            apply_check();
          end
    // R5 R7 R8 R9 R12 register amounts, upper bits of rs_val as noise
    for (int p = 0; p < 6; p++)
      for (int k = 1; k < 8; k += 2)
        for (int a = 0; a < 20; a++)
          for (int ci = 0; ci < 2; ci++) begin
            imm_mode = 0; value = pats[p]; kind = 3'(k); imm_amt = 5'(a);
            rs_val = 32'(reg_amts[a]) | (32'(p) << 12); carry_in = ci[0];
            apply_check();
          end
    // R10 R11 immediate-operand mode
    for (int kc = 0; kc < 256; kc++)
      for (int rf = 0; rf < 16; rf++)
        for (int ci = 0; ci < 2; ci++) begin
          imm_mode = 1; imm_const = 8'(kc); rot_field = 4'(rf); carry_in = ci[0];
          value = 32'hA5A5_5A5A; kind = 3'b111; rs_val = 32'd5;
          apply_check();
        end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule